// File: doc/BRIEF.md
# Flash Rewrite Mode Control Register

This block holds the control bits that let a processor put its on-chip flash into software-driven rewrite mode. It keeps four control bits: a user-ROM area select bit, the rewrite-mode enable, a lock-bit override and a flash power-down bit. It also keeps a reserved-window expansion bit in a second register. The three sensitive bits (rewrite-mode, lock override, power-down) are protected by a key sequence. They go to 1 only when a write that clears the bit is followed by a write that sets it, with no other register write between the two. Writes that come from code fetched out of the flash itself cannot change the rewrite-mode, power-down or ROM-select bits.

A non-maskable interrupt or a watchdog event sends the flash back to read-array mode. The block then clears rewrite mode and tells the flash sequencer to drop any erase or program operation in progress. The expansion bit follows the rewrite-mode bit and can also be written directly. While the expansion bit is 0, it gates access to a reserved 64 KiB address window.

Top module: `flash_rw_ctrl`

## Requirements
- R1: After reset, all four control bits, the expansion bit and both pulse outputs are 0. Reset is asynchronous and takes effect at once, even while rewrite mode is on.
- R2: The keyed bits of the control register are set only by a write of 1 that directly follows a control-register write holding 0 in that bit, with no register write in between. Cycles without a write may occur between the two writes. The keyed bits are bit 1 (rewrite mode), bit 2 (lock override) and bit 3 (power-down).
- R3: Writing 1 to a keyed bit that is not armed leaves the bit at 0. A bit is not armed when any register write at any address came between its 0 write and its 1 write, or when the previous write already held 1 in that bit.
- R4: A control-register write holding 0 in a bit clears that bit at the next clock edge, with no key sequence.
- R5: While `fetch_in_flash` is 1, a control-register write leaves bits 0, 1 and 3 unchanged and does not arm them. Bit 2 is still written.
- R6: Bit 0 (ROM area select) takes the written value on any accepted control-register write, with no key sequence.
- R7: In the same cycle in which the rewrite-mode bit goes from 0 to 1, the expansion bit becomes 1. In the same cycle in which the rewrite-mode bit goes from 1 to 0, the expansion bit becomes 0. At other times, a write to the system register loads the expansion bit from data bit 3.
- R8: A 1 on `nmi_evt` or `wdt_evt` at a clock edge gives a one-cycle `force_read_pulse` after that edge. At the same edge it clears rewrite mode, and with it the expansion bit, even if a key write arrives in the same cycle.
- R9: `abort_pulse` is asserted for that same cycle only if rewrite mode was 1 when the event was sampled.
- R10: `acc_ok` is 0 for an `acc_addr` in 0x0C0000..0x0CFFFF while the expansion bit is 0. It is 1 for every address outside that window, and for every address inside it once the expansion bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| fetch_in_flash | input | 1 | Issuing code is fetched from the internal flash |
| nmi_evt | input | 1 | Non-maskable interrupt event |
| wdt_evt | input | 1 | Watchdog event |
| acc_addr | input | MEM_AW | Address probed against the reserved window |
| rom_sel | output | 1 | User-ROM area select bit |
| rw_mode | output | 1 | Rewrite-mode enable bit |
| lock_dis | output | 1 | Lock-bit override bit |
| flash_off | output | 1 | Flash power-down bit |
| area_exp | output | 1 | Reserved-window expansion bit |
| force_read_pulse | output | 1 | One-cycle request to return the flash to read-array mode |
| abort_pulse | output | 1 | One-cycle request to drop an erase or program operation |
| acc_ok | output | 1 | Access to `acc_addr` is allowed |

## Verification
The key logic is tried with four kinds of write sequence: a clean 0-then-1 pair, a pair with a write to another address in between, a 1 repeated without a fresh 0, and a pair with idle cycles between the writes. These show that arming is counted in writes and not in cycles. The same pairs issued with `fetch_in_flash` high show which bits the fetch guard covers and which it leaves writable. Events are applied with rewrite mode on and with it off. This shows that the read-array request always fires, while the abort request depends on the mode. The window is probed just below, at both ends of and just above the reserved range, with the expansion bit at 0 and at 1.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;
  localparam int CTL_W = 4;
  localparam int B_ROM = 0;
  localparam int B_RWM = 1;
  localparam int B_LKD = 2;
  localparam int B_PWO = 3;
  localparam logic [CTL_W-1:0] KEY_MASK   = 4'b1110;
  localparam logic [CTL_W-1:0] GUARD_MASK = 4'b1011;
endpackage

// File: rtl/flash_rw_keybits.sv
module flash_rw_keybits #(
  parameter int NB = 4,
  parameter logic [NB-1:0] KEYED   = '0,
  parameter logic [NB-1:0] GUARDED = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_wr,
  input  logic          ctl_hit,
  input  logic          in_flash,
  input  logic [NB-1:0] wdata,
  input  logic [NB-1:0] clr,
  output logic [NB-1:0] bits_q,
  output logic [NB-1:0] bits_nxt
);
  logic [NB-1:0] arm_q, arm_nxt;

  for (genvar k = 0; k < NB; k++) begin : g_bit
    logic hit_ok;
    assign hit_ok = ctl_hit & ~(GUARDED[k] & in_flash);

    always_comb begin
      arm_nxt[k]  = arm_q[k];
      bits_nxt[k] = bits_q[k];
      if (any_wr)
        arm_nxt[k] = hit_ok & ~wdata[k];
      if (clr[k])
        bits_nxt[k] = 1'b0;
      else if (hit_ok && !wdata[k])
        bits_nxt[k] = 1'b0;
      else if (hit_ok && wdata[k] && (arm_q[k] || !KEYED[k]))
        bits_nxt[k] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      bits_q <= '0;
    end else begin
      arm_q  <= arm_nxt;
      bits_q <= bits_nxt;
    end
  end
endmodule

// File: rtl/flash_rw_evt.sv
module flash_rw_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi,
  input  logic wdt,
  input  logic mode_on,
  output logic evt_now,
  output logic force_read,
  output logic abort
);
  logic fr_nxt, ab_nxt;

  always_comb begin
    evt_now = nmi | wdt;
    fr_nxt  = evt_now;
    ab_nxt  = evt_now & mode_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_read <= 1'b0;
      abort      <= 1'b0;
    end else begin
      force_read <= fr_nxt;
      abort      <= ab_nxt;
    end
  end
endmodule

// File: rtl/flash_rw_window.sv
module flash_rw_window #(
  parameter int MEM_AW = 20,
  parameter logic [MEM_AW-1:0] WIN_LO = 20'hC0000,
  parameter logic [MEM_AW-1:0] WIN_HI = 20'hCFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_wr,
  input  logic              sys_bit,
  input  logic              mode_cur,
  input  logic              mode_nxt,
  input  logic [MEM_AW-1:0] addr,
  output logic              exp_q,
  output logic              ok
);
  logic exp_nxt, in_win;

  always_comb begin
    exp_nxt = exp_q;
    if (mode_nxt && !mode_cur)
      exp_nxt = 1'b1;
    else if (!mode_nxt && mode_cur)
      exp_nxt = 1'b0;
    else if (sys_wr)
      exp_nxt = sys_bit;
    in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
    ok     = ~in_win | exp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_q <= 1'b0;
    else        exp_q <= exp_nxt;
  end
endmodule

// File: rtl/flash_rw_ctrl.sv
module flash_rw_ctrl
  import flash_rw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 10'h0A0,
  parameter logic [ADDR_W-1:0] SYS_ADDR = 10'h0A1,
  parameter int EXP_POS = 3,
  parameter int MEM_AW = 20,
  parameter logic [MEM_AW-1:0] WIN_LO = 20'hC0000,
  parameter logic [MEM_AW-1:0] WIN_HI = 20'hCFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fetch_in_flash,
  input  logic              nmi_evt,
  input  logic              wdt_evt,
  input  logic [MEM_AW-1:0] acc_addr,
  output logic              rom_sel,
  output logic              rw_mode,
  output logic              lock_dis,
  output logic              flash_off,
  output logic              area_exp,
  output logic              force_read_pulse,
  output logic              abort_pulse,
  output logic              acc_ok
);
  logic             ctl_hit, sys_hit, evt_now;
  logic [CTL_W-1:0] clr_vec, bits_q, bits_nxt;

  always_comb begin
    ctl_hit = wr_en && (wr_addr == CTL_ADDR);
    sys_hit = wr_en && (wr_addr == SYS_ADDR);
    clr_vec = '0;
    clr_vec[B_RWM] = evt_now;
  end

  flash_rw_keybits #(.NB(CTL_W), .KEYED(KEY_MASK), .GUARDED(GUARD_MASK)) u_keys (
    .clk(clk), .rst_n(rst_n), .any_wr(wr_en), .ctl_hit(ctl_hit),
    .in_flash(fetch_in_flash), .wdata(wr_data[CTL_W-1:0]), .clr(clr_vec),
    .bits_q(bits_q), .bits_nxt(bits_nxt)
  );

  flash_rw_evt u_evt (
    .clk(clk), .rst_n(rst_n), .nmi(nmi_evt), .wdt(wdt_evt),
    .mode_on(bits_q[B_RWM]), .evt_now(evt_now),
    .force_read(force_read_pulse), .abort(abort_pulse)
  );

  flash_rw_window #(.MEM_AW(MEM_AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .clk(clk), .rst_n(rst_n), .sys_wr(sys_hit), .sys_bit(wr_data[EXP_POS]),
    .mode_cur(bits_q[B_RWM]), .mode_nxt(bits_nxt[B_RWM]), .addr(acc_addr),
    .exp_q(area_exp), .ok(acc_ok)
  );

  assign rom_sel   = bits_q[B_ROM];
  assign rw_mode   = bits_q[B_RWM];
  assign lock_dis  = bits_q[B_LKD];
  assign flash_off = bits_q[B_PWO];
endmodule

// File: rtl/flash_rw_ctrl_chk.sv
module flash_rw_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 10'h0A0,
  parameter int MEM_AW = 20,
  parameter logic [MEM_AW-1:0] WIN_LO = 20'hC0000,
  parameter logic [MEM_AW-1:0] WIN_HI = 20'hCFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              fetch_in_flash,
  input logic              nmi_evt,
  input logic              wdt_evt,
  input logic [MEM_AW-1:0] acc_addr,
  input logic              rw_mode,
  input logic              lock_dis,
  input logic              flash_off,
  input logic              area_exp,
  input logic              force_read_pulse,
  input logic              abort_pulse,
  input logic              acc_ok
);
  assert_lock_set_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_dis) |-> $past(wr_en && wr_addr == CTL_ADDR && wr_data[2]));

  assert_pwo_guarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_off) |-> $past(!fetch_in_flash));

  assert_exp_follows_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rw_mode) |-> area_exp);

  assert_exp_follows_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rw_mode) |-> !area_exp);

  assert_event_forces_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt || wdt_evt) |=> (force_read_pulse && !rw_mode));

  assert_abort_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((nmi_evt || wdt_evt) && rw_mode) |=> abort_pulse);

  assert_abort_only_from_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> force_read_pulse);

  assert_window_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >= WIN_LO && acc_addr <= WIN_HI && !area_exp) |-> !acc_ok);
endmodule

bind flash_rw_ctrl flash_rw_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR),
  .MEM_AW(MEM_AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .fetch_in_flash(fetch_in_flash), .nmi_evt(nmi_evt), .wdt_evt(wdt_evt),
  .acc_addr(acc_addr), .rw_mode(rw_mode), .lock_dis(lock_dis),
  .flash_off(flash_off), .area_exp(area_exp), .force_read_pulse(force_read_pulse),
  .abort_pulse(abort_pulse), .acc_ok(acc_ok)
);

// File: tb/flash_rw_ctrl_tb.sv
module flash_rw_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;
  localparam logic [9:0] CTL = 10'h0A0;
  localparam logic [9:0] SYS = 10'h0A1;
  localparam logic [9:0] OTH = 10'h0B3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic fetch_in_flash = 1'b0;
  logic nmi_evt = 1'b0;
  logic wdt_evt = 1'b0;
  logic [19:0] acc_addr = '0;
  logic rom_sel, rw_mode, lock_dis, flash_off, area_exp;
  logic force_read_pulse, abort_pulse, acc_ok;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rw_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fetch_in_flash(fetch_in_flash), .nmi_evt(nmi_evt), .wdt_evt(wdt_evt),
    .acc_addr(acc_addr), .rom_sel(rom_sel), .rw_mode(rw_mode), .lock_dis(lock_dis),
    .flash_off(flash_off), .area_exp(area_exp), .force_read_pulse(force_read_pulse),
    .abort_pulse(abort_pulse), .acc_ok(acc_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d, input logic inf);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; fetch_in_flash = inf;
    @(negedge clk);
    wr_en = 1'b0; fetch_in_flash = 1'b0;
  endtask

  task automatic probe(input string req, input logic [19:0] a, input int exp);
    acc_addr = a;
    #1;
    chk(req, int'(acc_ok), exp);
  endtask

  task automatic t_reset;
    chk("R1 rom_sel", rom_sel, 0);
    chk("R1 rw_mode", rw_mode, 0);
    chk("R1 lock_dis", lock_dis, 0);
    chk("R1 flash_off", flash_off, 0);
    chk("R1 area_exp", area_exp, 0);
    chk("R1 pulses", int'(force_read_pulse | abort_pulse), 0);
    probe("R10 win low end closed", 20'hC0000, 0);
    probe("R10 win high end closed", 20'hCFFFF, 0);
    probe("R10 below win", 20'hBFFFF, 1);
    probe("R10 above win", 20'hD0000, 1);
  endtask

  task automatic t_key;
    wr(CTL, 8'h00, 1'b0);
    wr(CTL, 8'h02, 1'b0);
    chk("R2 rw_mode set by pair", rw_mode, 1);
    chk("R7 exp set with mode", area_exp, 1);
    probe("R10 win open after exp", 20'hC8000, 1);
    wr(CTL, 8'h06, 1'b0);
    chk("R2 lock_dis set by pair", lock_dis, 1);
    wr(CTL, 8'h00, 1'b0);
    chk("R4 rw_mode cleared", rw_mode, 0);
    chk("R4 lock_dis cleared", lock_dis, 0);
    chk("R7 exp cleared with mode", area_exp, 0);
  endtask

  task automatic t_broken;
    wr(CTL, 8'h00, 1'b0);
    wr(OTH, 8'h00, 1'b0);
    wr(CTL, 8'h08, 1'b0);
    chk("R3 intervening write blocks", flash_off, 0);
    wr(CTL, 8'h08, 1'b0);
    chk("R3 repeated 1 blocks", flash_off, 0);
    wr(CTL, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    wr(CTL, 8'h08, 1'b0);
    chk("R2 idle cycles allowed", flash_off, 1);
    wr(CTL, 8'h00, 1'b0);
    chk("R4 flash_off cleared", flash_off, 0);
  endtask

  task automatic t_flash;
    wr(CTL, 8'h00, 1'b1);
    wr(CTL, 8'h0F, 1'b1);
    chk("R5 rw_mode guarded", rw_mode, 0);
    chk("R5 flash_off guarded", flash_off, 0);
    chk("R5 rom_sel guarded", rom_sel, 0);
    chk("R5 lock_dis still written", lock_dis, 1);
    wr(CTL, 8'h01, 1'b0);
    chk("R6 rom_sel plain write", rom_sel, 1);
    chk("R4 lock_dis cleared by 0", lock_dis, 0);
    wr(CTL, 8'h01, 1'b0);
    wr(CTL, 8'h03, 1'b0);
    chk("R2 rw_mode set", rw_mode, 1);
    wr(CTL, 8'h00, 1'b1);
    chk("R5 clear from flash ignored", rw_mode, 1);
    chk("R5 rom_sel kept", rom_sel, 1);
  endtask

  task automatic t_event;
    @(negedge clk); nmi_evt = 1'b1;
    @(negedge clk); nmi_evt = 1'b0;
    chk("R8 force_read on nmi", force_read_pulse, 1);
    chk("R9 abort with mode on", abort_pulse, 1);
    chk("R8 rw_mode cleared", rw_mode, 0);
    chk("R7 exp cleared by event", area_exp, 0);
    @(negedge clk);
    chk("R8 force_read one cycle", force_read_pulse, 0);
    chk("R9 abort one cycle", abort_pulse, 0);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk); wdt_evt = 1'b0;
    chk("R8 force_read on wdt", force_read_pulse, 1);
    chk("R9 no abort with mode off", abort_pulse, 0);
    wr(CTL, 8'h00, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = CTL; wr_data = 8'h02; wdt_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdt_evt = 1'b0;
    chk("R8 event beats key write", rw_mode, 0);
  endtask

  task automatic t_sys;
    wr(SYS, 8'h08, 1'b0);
    chk("R7 direct exp write", area_exp, 1);
    probe("R10 win low open", 20'hC0000, 1);
    probe("R10 win high open", 20'hCFFFF, 1);
    wr(SYS, 8'h00, 1'b0);
    chk("R7 direct exp clear", area_exp, 0);
    probe("R10 win closed again", 20'hC0001, 0);
  endtask

  task automatic t_reset_mid;
    wr(CTL, 8'h00, 1'b0);
    wr(CTL, 8'h0A, 1'b0);
    chk("R2 mode before reset", rw_mode, 1);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 reset in rewrite mode", rw_mode, 0);
    chk("R1 reset clears exp", area_exp, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_key;
    t_broken;
    t_flash;
    t_event;
    t_sys;
    t_reset_mid;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule